// File: doc/BRIEF.md
# Clock Domain Source Selector and Divider

This block models a single clock domain of a chip-level clock controller, running entirely inside one fast simulation clock. Five source strobes arrive, one per candidate source: a 32.768 kHz real-time clock, a 26 MHz crystal oscillator, and three PLL outputs. Each strobe is high for one fast cycle per source edge. The block picks one source, divides it by a programmable ratio, and drives a gated domain clock level. A bypass path can pass the chosen source through undivided.

Software reaches the block through a 32-bit configuration word. It has a write port and a read port that always shows the current register state. Source changes and ratio changes are requested through this word and are not applied at once. Each one raises a status flag, takes effect at the end of the current output period, and then clears its flag, so software can poll for completion.

A separate enable input forces the output low. It does not touch the divider or the configuration. A parameter narrows the count fields to 3 bits, and another ties the domain permanently to the third PLL.

Top module: `clk_domain_div`

## Requirements
- R1: After reset the configuration word reads 0x00000001 (source 1, both counts 0, bypass and both status flags clear); in a domain tied to the third PLL it reads 0x00000004.
- R2: Field [2:0] picks the source. Code 0 is the real-time clock, 1 the oscillator, and 2, 3 and 4 are the first, second and third PLL. The output timing follows the strobe of the chosen source only.
- R3: A write carrying a select code of 0 to 4 sets bit 3 in the next cycle. Bit 3 clears once the new source is in use.
- R4: A write carrying a select code of 5, 6 or 7 leaves the active source and the field [2:0] readback unchanged, and does not set bit 3.
- R5: When not bypassed, the output is high for wait+1 source strobes and low for hold+1 source strobes, a period of wait+hold+2. The wait count sits in bits [19:16] and the hold count in bits [23:20].
- R6: A write with bit 25 set captures new wait and hold counts and sets bit 25. Bit 25 clears once they are in use. A write with bit 25 clear leaves both counts unchanged.
- R7: With bit 24 set, the output is high in the cycle after each strobe of the chosen source and low otherwise.
- R8: With 3-bit counts, bits 19 and 23 read as zero and the longest period is 16 strobes. Bits [15:4] and [31:26] always read as zero.
- R9: In a domain tied to the third PLL, field [2:0] always reads 4. Select writes are ignored, bit 3 never sets, and the output follows strobe 4.
- R10: While the enable input is low, the output is low from the next cycle on. The configuration and the ratio are kept, and the same ratio resumes when the enable returns.
- R11: A new ratio or source is adopted only at the end of a complete low phase. A high phase in progress when a new ratio is written keeps its old length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast simulation clock |
| rst | input | 1 | Synchronous active-high reset |
| src_en | input | NUM_SRC | One-cycle strobes, one per source, index equals select code |
| dom_en | input | 1 | Domain enable; low forces the output low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current configuration and status word |
| dom_out | output | 1 | Registered domain clock level |

## Verification
The bench drives each source with a different strobe spacing. A design that routed the wrong source, or counted fast cycles instead of strobes, therefore shows the wrong high and low run lengths.

It writes a new ratio while a high phase is in progress. A design that adopted the ratio immediately would cut that pulse short.

It writes invalid select codes and ratio fields with the update flag clear. A design that let either through would change the readback or the period. It also checks a narrow-count domain tied to the third PLL, where a design that kept the fourth count bit would read back 15 and run at more than a ratio of 16.

// File: rtl/clk_domain_pkg.sv
package clk_domain_pkg;
  localparam int CFG_W          = 32;
  localparam int SEL_W          = 3;
  localparam int SEL_LSB        = 0;
  localparam int BUSY_BIT       = 3;
  localparam int WAIT_LSB       = 16;
  localparam int HOLD_LSB       = 20;
  localparam int BYP_BIT        = 24;
  localparam int UPD_BIT        = 25;
  localparam int LAST_SRC       = 4;
  localparam int RESET_SRC      = 1;
  localparam int FIXED_SRC_CODE = 4;

  typedef logic [SEL_W-1:0] src_sel_t;
endpackage

// File: rtl/cdom_cfg_regs.sv
module cdom_cfg_regs
  import clk_domain_pkg::*;
#(
  parameter int CNT_W      = 4,
  parameter bit FIXED_PLL3 = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  input  logic             period_end,
  output logic [CFG_W-1:0] rdata,
  output src_sel_t         act_sel,
  output logic [CNT_W-1:0] act_wait,
  output logic [CNT_W-1:0] act_hold,
  output logic             byp
);
  localparam src_sel_t INIT_SEL = FIXED_PLL3 ? src_sel_t'(FIXED_SRC_CODE)
                                             : src_sel_t'(RESET_SRC);

  src_sel_t         sel_q;
  logic             busy_q;
  logic             upd_q;
  logic [CNT_W-1:0] wait_q;
  logic [CNT_W-1:0] hold_q;
  logic             sel_ok;

  assign sel_ok = !FIXED_PLL3 &&
                  (wdata[SEL_LSB +: SEL_W] <= src_sel_t'(LAST_SRC));

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= INIT_SEL;
      act_sel  <= INIT_SEL;
      busy_q   <= 1'b0;
      upd_q    <= 1'b0;
      wait_q   <= '0;
      hold_q   <= '0;
      act_wait <= '0;
      act_hold <= '0;
      byp      <= 1'b0;
    end else begin
      // Pending changes land on a period boundary.
      if (period_end) begin
        if (busy_q) begin
          act_sel <= sel_q;
          busy_q  <= 1'b0;
        end
        if (upd_q) begin
          act_wait <= wait_q;
          act_hold <= hold_q;
          upd_q    <= 1'b0;
        end
      end
      // A write in the same cycle wins and stays pending.
      if (we) begin
        byp <= wdata[BYP_BIT];
        if (sel_ok) begin
          sel_q  <= wdata[SEL_LSB +: SEL_W];
          busy_q <= 1'b1;
        end
        if (wdata[UPD_BIT]) begin
          wait_q <= wdata[WAIT_LSB +: CNT_W];
          hold_q <= wdata[HOLD_LSB +: CNT_W];
          upd_q  <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rdata                     = '0;
    rdata[SEL_LSB +: SEL_W]   = sel_q;
    rdata[BUSY_BIT]           = busy_q;
    rdata[WAIT_LSB +: CNT_W]  = wait_q;
    rdata[HOLD_LSB +: CNT_W]  = hold_q;
    rdata[BYP_BIT]            = byp;
    rdata[UPD_BIT]            = upd_q;
  end
endmodule

// File: rtl/cdom_src_mux.sv
module cdom_src_mux
  import clk_domain_pkg::*;
#(
  parameter int NUM_SRC    = 5,
  parameter bit FIXED_PLL3 = 1'b0
) (
  input  logic [NUM_SRC-1:0] src_en,
  input  src_sel_t           sel,
  output logic               tick
);
  generate
    if (FIXED_PLL3) begin : g_fixed
      assign tick = src_en[FIXED_SRC_CODE];
    end else begin : g_sel
      always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NUM_SRC; i++) begin
          if (sel == src_sel_t'(i)) tick = src_en[i];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/cdom_ratio_div.sv
module cdom_ratio_div #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             byp,
  input  logic [CNT_W-1:0] wait_cnt,
  input  logic [CNT_W-1:0] hold_cnt,
  input  logic             dom_en,
  output logic             period_end,
  output logic             dom_out
);
  logic             phase_hi;
  logic [CNT_W-1:0] cnt;

  assign period_end = tick & (byp | (!phase_hi && cnt == hold_cnt));

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_hi <= 1'b1;
      cnt      <= '0;
      dom_out  <= 1'b0;
    end else begin
      dom_out <= dom_en & (byp ? tick : phase_hi);
      if (tick) begin
        if (byp || period_end) begin
          phase_hi <= 1'b1;
          cnt      <= '0;
        end else if (phase_hi && cnt == wait_cnt) begin
          phase_hi <= 1'b0;
          cnt      <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/clk_domain_div.sv
module clk_domain_div
  import clk_domain_pkg::*;
#(
  parameter int NUM_SRC    = 5,
  parameter int CNT_W      = 4,
  parameter bit FIXED_PLL3 = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_en,
  input  logic               dom_en,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CFG_W-1:0]   cfg_rdata,
  output logic               dom_out
);
  src_sel_t         act_sel;
  logic [CNT_W-1:0] act_wait;
  logic [CNT_W-1:0] act_hold;
  logic             byp;
  logic             tick;
  logic             period_end;

  cdom_cfg_regs #(.CNT_W(CNT_W), .FIXED_PLL3(FIXED_PLL3)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .period_end(period_end), .rdata(cfg_rdata), .act_sel(act_sel),
    .act_wait(act_wait), .act_hold(act_hold), .byp(byp)
  );

  cdom_src_mux #(.NUM_SRC(NUM_SRC), .FIXED_PLL3(FIXED_PLL3)) u_mux (
    .src_en(src_en), .sel(act_sel), .tick(tick)
  );

  cdom_ratio_div #(.CNT_W(CNT_W)) u_div (
    .clk(clk), .rst(rst), .tick(tick), .byp(byp), .wait_cnt(act_wait),
    .hold_cnt(act_hold), .dom_en(dom_en), .period_end(period_end),
    .dom_out(dom_out)
  );
endmodule

// File: rtl/clk_domain_div_chk.sv
module clk_domain_div_chk #(
  parameter int NUM_SRC    = 5,
  parameter int CNT_W      = 4,
  parameter bit FIXED_PLL3 = 1'b0
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] src_en,
  input logic               dom_en,
  input logic               cfg_we,
  input logic [31:0]        cfg_wdata,
  input logic [31:0]        cfg_rdata,
  input logic               dom_out
);
  // R4
  invalid_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_wdata[2:0] > 3'd4 && !cfg_rdata[3])
    |=> (!cfg_rdata[3] && cfg_rdata[2:0] == $past(cfg_rdata[2:0])));

  // R10
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    !dom_en |=> !dom_out);

  // R6
  upd_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_wdata[25]) |=> cfg_rdata[25]);

  // R8
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_rdata[31:26] == 6'd0 && cfg_rdata[15:4] == 12'd0 &&
     (cfg_rdata[19:16] >> CNT_W) == 4'd0 && (cfg_rdata[23:20] >> CNT_W) == 4'd0));

  // R7
  bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (dom_en && cfg_rdata[24] && !cfg_rdata[3] && !cfg_we &&
     src_en[cfg_rdata[2:0]]) |=> dom_out);

  generate
    if (FIXED_PLL3) begin : g_fix
      // R9
      fixed_sel_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg_rdata[2:0] == 3'd4 && !cfg_rdata[3]));
    end else begin : g_sel
      // R3
      busy_set_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_wdata[2:0] <= 3'd4) |=> cfg_rdata[3]);
    end
  endgenerate
endmodule

bind clk_domain_div clk_domain_div_chk #(
  .NUM_SRC(NUM_SRC), .CNT_W(CNT_W), .FIXED_PLL3(FIXED_PLL3)
) u_chk (
  .clk(clk), .rst(rst), .src_en(src_en), .dom_en(dom_en), .cfg_we(cfg_we),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .dom_out(dom_out)
);

// File: tb/sim_clk_domain_div.sv
`timescale 1ns/1ps
module sim_clk_domain_div;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  src_en = '0;
  logic        dom_en0 = 1'b0, dom_en1 = 1'b0;
  logic        we0 = 1'b0, we1 = 1'b0;
  logic [31:0] wd0 = '0, wd1 = '0;
  logic [31:0] rd0, rd1;
  logic        out0, out1;

  int n_chk = 0;
  int n_fail = 0;
  int per [5] = '{7, 1, 2, 3, 4};

  always #2 clk = ~clk;

  clk_domain_div u0 (
    .clk(clk), .rst(rst), .src_en(src_en), .dom_en(dom_en0), .cfg_we(we0),
    .cfg_wdata(wd0), .cfg_rdata(rd0), .dom_out(out0)
  );

  clk_domain_div #(.CNT_W(3), .FIXED_PLL3(1'b1)) u1 (
    .clk(clk), .rst(rst), .src_en(src_en), .dom_en(dom_en1), .cfg_we(we1),
    .cfg_wdata(wd1), .cfg_rdata(rd1), .dom_out(out1)
  );

  // Periodic source strobes, changed away from the active edge.
  initial begin
    int t = 0;
    forever begin
      @(negedge clk);
      for (int i = 0; i < 5; i++) src_en[i] = ((t % per[i]) == 0);
      t++;
    end
  end

  function automatic logic [31:0] mk(int sel, int w, int h, bit byp, bit upd);
    logic [31:0] v = '0;
    v[2:0] = 3'(sel);
    v[19:16] = 4'(w);
    v[23:20] = 4'(h);
    v[24] = byp;
    v[25] = upd;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic get_out(bit u);
    return u ? out1 : out0;
  endfunction

  function automatic logic [31:0] get_rd(bit u);
    return u ? rd1 : rd0;
  endfunction

  task automatic wr(bit u, logic [31:0] d);
    @(negedge clk);
    if (u) begin we1 = 1'b1; wd1 = d; end else begin we0 = 1'b1; wd0 = d; end
    @(negedge clk);
    we0 = 1'b0;
    we1 = 1'b0;
  endtask

  task automatic poll(bit u, string req);
    int n = 0;
    while ((get_rd(u)[3] || get_rd(u)[25]) && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check({req, " status clears"}, int'(n < 3000), 1);
  endtask

  task automatic wait_rise(bit u);
    int n = 0;
    while (get_out(u) && n < 3000) begin @(negedge clk); n++; end
    while (!get_out(u) && n < 3000) begin @(negedge clk); n++; end
  endtask

  // Skip one period so alignment after a change does not matter.
  task automatic measure(bit u, output int hi, output int lo);
    wait_rise(u);
    wait_rise(u);
    hi = 0;
    lo = 0;
    while (get_out(u) && hi < 3000) begin @(negedge clk); hi++; end
    while (!get_out(u) && lo < 3000) begin @(negedge clk); lo++; end
  endtask

  task automatic check_ratio(bit u, int s, int w, int h, string req);
    int hi, lo;
    measure(u, hi, lo);
    check({req, " high run"}, hi, (w + 1) * per[s]);
    check({req, " low run"}, lo, (h + 1) * per[s]);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int hi, lo, s, w, h;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 reset word", rd0, 32'h1);
    check("R1 reset word fixed", rd1, 32'h4);
    check("R1 reset output", int'(out0), 0);
    dom_en0 = 1'b1;
    dom_en1 = 1'b1;
    check_ratio(0, 1, 0, 0, "R5 reset ratio");

    // Random sources and ratios: R2 R3 R5 R6
    for (int k = 0; k < 7; k++) begin
      s = int'($urandom % 5);
      w = int'($urandom % 16);
      h = int'($urandom % 16);
      wr(0, mk(s, w, h, 0, 1));
      check("R3 busy set", int'(rd0[3]), 1);
      check("R6 update set", int'(rd0[25]), 1);
      poll(0, "R3 R6");
      check("R6 readback", rd0, mk(s, w, h, 0, 0));
      check_ratio(0, s, w, h, "R2 R5 random");
    end

    // Longest ratio on PLL1: R5
    wr(0, mk(2, 15, 15, 0, 1));
    poll(0, "R5");
    check_ratio(0, 2, 15, 15, "R5 max ratio");

    wr(0, mk(1, 2, 1, 0, 1));
    poll(0, "R5");
    check_ratio(0, 1, 2, 1, "R5 small ratio");

    // Invalid select: R4
    for (int c = 5; c < 8; c++) begin
      wr(0, mk(c, 0, 0, 0, 0));
      check("R4 no busy", int'(rd0[3]), 0);
      check("R4 select kept", int'(rd0[2:0]), 1);
    end
    check_ratio(0, 1, 2, 1, "R4 source kept");

    // Counts without update flag ignored: R6
    wr(0, mk(1, 9, 9, 0, 0));
    poll(0, "R6");
    check("R6 counts kept", rd0, mk(1, 2, 1, 0, 0));
    check_ratio(0, 1, 2, 1, "R6 ratio kept");

    // Change during a high phase: R11
    wait_rise(0);
    hi = 1;
    we0 = 1'b1;
    wd0 = mk(1, 6, 1, 0, 1);
    @(negedge clk);
    we0 = 1'b0;
    while (out0 && hi < 3000) begin hi++; @(negedge clk); end
    check("R11 high phase not cut", hi, 3);
    poll(0, "R11");
    check_ratio(0, 1, 6, 1, "R11 new ratio");

    // Bypass on source 3: R7
    wr(0, mk(3, 6, 1, 1, 0));
    poll(0, "R7");
    repeat (6) @(negedge clk);
    begin
      int highs = 0, pairs = 0;
      logic prev = 1'b0;
      for (int i = 0; i < 60; i++) begin
        if (out0) highs++;
        if (out0 && prev) pairs++;
        prev = out0;
        @(negedge clk);
      end
      check("R7 bypass pulse count", highs, 60 / per[3]);
      check("R7 single-cycle pulses", pairs, 0);
    end
    wr(0, mk(3, 6, 1, 0, 0));
    poll(0, "R7");
    check_ratio(0, 3, 6, 1, "R7 bypass off");

    // Enable gating: R10
    @(negedge clk);
    dom_en0 = 1'b0;
    @(negedge clk);
    begin
      int highs = 0;
      for (int i = 0; i < 80; i++) begin
        if (out0) highs++;
        @(negedge clk);
      end
      check("R10 gated low", highs, 0);
    end
    check("R10 config kept", rd0, mk(3, 6, 1, 0, 0));
    dom_en0 = 1'b1;
    check_ratio(0, 3, 6, 1, "R10 resume");

    // Fixed narrow domain: R8 R9
    wr(1, mk(0, 15, 15, 0, 1));
    check("R9 no busy", int'(rd1[3]), 0);
    check("R9 select reads 4", int'(rd1[2:0]), 4);
    poll(1, "R9");
    check("R8 narrow counts", rd1, mk(4, 7, 7, 0, 0));
    check_ratio(1, 4, 7, 7, "R8 R9 ratio 16 on source 4");

    finish_run();
  end
endmodule